// File: doc/BRIEF.md
# Panel Self-Refresh Source Controller

This block is the sequencing core on the source side of a display link that can hand refresh duty to the panel. When the frame buffer has been quiet long enough, the source stops streaming pixels. The panel then repaints itself from its local copy. When the host needs to change the picture, the source takes the stream back.

The controller is a six-state machine. Some of its moves are commanded by the host: enable, activate, exit, and a one-shot single-frame update. Other moves happen on their own: the end of the static-frame phase, the end of a single-frame update, and the return after a wake. It counts quiet frames against a programmable threshold. It emits a one-cycle wake strobe that a separate sideband engine turns into a power-state write to the sink. It also bounds the wait for that engine's acknowledge with a cycle budget. A small encoder turns a requested wake-up time into a two-bit time code.

Top module: `psr_src_ctrl`

## Requirements
- R1: `state_o` carries the state code: 0 off, 1 idle (enabled, refreshing), 2 entry (static frame sent), 3 self-refresh active, 4 single-frame update, 5 exit. After reset the state is 0 and `wake_req_o`, `sfu_pend_o`, `err_o` and `timeout_o` are low.
- R2: In state 0, `enable_i` high moves the machine to state 1 on the next clock. No sequence of enable alone takes it past state 1.
- R3: In state 1 with `enable_i` high, an `activate_i` pulse moves the machine to state 2 on the next clock.
- R4: In state 2 the machine counts `vsync_i` strobes. A strobe closing a frame in which `upd_i` was seen (including on the strobe cycle) restarts the count. The strobe that completes N consecutive clean frames moves the machine to state 3, where N = max(6, `idle_cfg_i`).
- R5: In state 3 with `enable_i` high, an `exit_i` pulse moves the machine to state 5 on the next clock, without passing through state 4.
- R6: `wake_req_o` is high for exactly the first cycle of state 5. In state 5, `wake_ack_i` high moves the machine to state 1 on the next clock.
- R7: An `sfu_req_i` pulse in any state other than 0 sets `sfu_pend_o`. In state 3 with the flag set, a `vsync_i` strobe moves the machine to state 4. The next strobe returns it to state 3 and clears the flag. Entering state 0 also clears it.
- R8: `wake_code_o` encodes `wake_time_i` as v: v > 5 gives 3 (2500 us), v > 1 gives 2 (500 us), v > 0 gives 1 (100 us), otherwise 0 (0 us).
- R9: `in_trans_o` is high exactly while the state is 2 or 5.
- R10: With `enable_i` low, states 1, 3 and 4 move to state 0 on the next clock. States 2 and 5 hold until their own transition completes, then continue to state 0.
- R11: An activate outside state 1, an exit outside states 3 and 4, or a single-frame request in state 0 changes no state and sets the sticky `err_o`.
- R12: If no acknowledge arrives, state 5 lasts `ack_limit_i`+1 cycles. The machine then moves to state 1 and sets the sticky `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Feature enable level |
| activate_i | input | 1 | Request to begin self-refresh entry |
| exit_i | input | 1 | Request to leave self-refresh |
| sfu_req_i | input | 1 | Request one frame update while self-refreshing |
| vsync_i | input | 1 | One-cycle frame boundary strobe |
| upd_i | input | 1 | Frame buffer written during the current frame |
| idle_cfg_i | input | 4 | Requested quiet-frame count before entry |
| wake_time_i | input | 4 | Requested wake-up time value |
| ack_limit_i | input | 16 | Cycle budget for the wake acknowledge |
| wake_ack_i | input | 1 | Acknowledge from the sideband engine |
| state_o | output | 3 | Current state code |
| in_trans_o | output | 1 | Machine is in a self-timed transition |
| wake_req_o | output | 1 | Wake strobe toward the sideband engine |
| wake_code_o | output | 2 | Encoded wake-up time |
| sfu_pend_o | output | 1 | Single-frame update pending |
| err_o | output | 1 | Sticky illegal-request flag |
| timeout_o | output | 1 | Sticky wake-acknowledge timeout flag |

## Verification
The bench goes after the quiet-frame count. If the design failed to clamp the threshold, it would enter after two frames. If it counted off by one, it would enter one strobe early or late. If it ignored an update on the strobe cycle itself, it would enter with a dirty frame. The exit path is probed for a detour through state 4, a wake strobe that lasts more than one cycle, and an acknowledge-budget off by one. The single-frame flag is watched for failing to clear on the return to state 3. A disable during entry is checked to make sure it does not cut the transition short. Illegal requests are checked to confirm they neither move the state nor go unrecorded.

// File: rtl/psr_pkg.sv
// Shared types for the panel self-refresh source controller.
// Assumes: a 3-bit state code whose values are visible to software.
package psr_pkg;

    typedef enum logic [2:0] {
        PSR_OFF    = 3'd0,
        PSR_IDLE   = 3'd1,
        PSR_ENTRY  = 3'd2,
        PSR_ACTIVE = 3'd3,
        PSR_SFU    = 3'd4,
        PSR_EXIT   = 3'd5
    } psr_state_e;

    typedef enum logic [1:0] {
        WAKE_0US    = 2'd0,
        WAKE_100US  = 2'd1,
        WAKE_500US  = 2'd2,
        WAKE_2500US = 2'd3
    } wake_code_e;

endpackage

// File: rtl/psr_wake_encode.sv
// Maps a requested wake-up time value onto a two-bit time code.
// Assumes: the value is unsigned; thresholds are fixed by the link rules.
module psr_wake_encode
    import psr_pkg::*;
#(
    parameter int VAL_W = 4
) (
    input  logic [VAL_W-1:0] req_i,
    output wake_code_e       code_o
);

    localparam logic [VAL_W-1:0] LIM_LONG = VAL_W'(5);
    localparam logic [VAL_W-1:0] LIM_MID  = VAL_W'(1);

    // Pick the smallest time bucket that covers the request.
    always_comb begin
        if (req_i > LIM_LONG)
            code_o = WAKE_2500US;
        else if (req_i > LIM_MID)
            code_o = WAKE_500US;
        else if (req_i != '0)
            code_o = WAKE_100US;
        else
            code_o = WAKE_0US;
    end

endmodule

// File: rtl/psr_idle_tracker.sv
// Counts consecutive frames with no frame-buffer write while entry runs.
// Assumes: vsync_i is a one-cycle strobe; the count restarts whenever run_i is low.
module psr_idle_tracker #(
    parameter int IDLE_W   = 4,
    parameter int MIN_IDLE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              vsync_i,
    input  logic              upd_i,
    input  logic [IDLE_W-1:0] cfg_i,
    output logic              reached_o
);

    localparam int CNT_W = IDLE_W + 1;
    localparam logic [IDLE_W-1:0] FLOOR = IDLE_W'(MIN_IDLE);

    logic [IDLE_W-1:0] thresh;
    logic [CNT_W-1:0]  cnt_q;
    logic              dirty_q;
    logic              frame_dirty;

    // Clamp the requested threshold to the minimum quiet-frame count.
    always_comb thresh = (cfg_i < FLOOR) ? FLOOR : cfg_i;

    // A frame is dirty if a write came earlier in it or on its closing strobe.
    always_comb frame_dirty = dirty_q | upd_i;

    // Completion fires on the strobe that closes the last needed clean frame.
    always_comb reached_o = run_i & vsync_i & ~frame_dirty &
                            ((cnt_q + CNT_W'(1)) >= {1'b0, thresh});

    // Track the dirty flag and the clean-frame count per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q   <= '0;
            dirty_q <= 1'b0;
        end else if (vsync_i) begin
            dirty_q <= 1'b0;
            if (frame_dirty)
                cnt_q <= '0;
            else if (cnt_q != {CNT_W{1'b1}})
                cnt_q <= cnt_q + CNT_W'(1);
        end else if (upd_i) begin
            dirty_q <= 1'b1;
        end
    end

endmodule

// File: rtl/psr_wake_timer.sv
// Bounds the wait for the wake acknowledge with a programmable cycle budget.
// Assumes: run_i stays high for the whole wait; the count restarts when it drops.
module psr_wake_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);

    logic [TMO_W-1:0] cnt_q;

    // Expire once the cycles spent waiting equal the budget.
    always_comb expire_o = run_i & (cnt_q == limit_i);

    // Count cycles spent waiting, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            cnt_q <= '0;
        else if (cnt_q != {TMO_W{1'b1}})
            cnt_q <= cnt_q + TMO_W'(1);
    end

endmodule

// File: rtl/psr_src_ctrl.sv
// Source-side self-refresh sequencer: six states, commanded and self-timed moves.
// Assumes: request inputs are one-cycle pulses synchronous to clk; enable is a level.
module psr_src_ctrl
    import psr_pkg::*;
#(
    parameter int IDLE_W   = 4,
    parameter int MIN_IDLE = 6,
    parameter int WAKE_W   = 4,
    parameter int TMO_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              activate_i,
    input  logic              exit_i,
    input  logic              sfu_req_i,
    input  logic              vsync_i,
    input  logic              upd_i,
    input  logic [IDLE_W-1:0] idle_cfg_i,
    input  logic [WAKE_W-1:0] wake_time_i,
    input  logic [TMO_W-1:0]  ack_limit_i,
    input  logic              wake_ack_i,
    output logic [2:0]        state_o,
    output logic              in_trans_o,
    output logic              wake_req_o,
    output logic [1:0]        wake_code_o,
    output logic              sfu_pend_o,
    output logic              err_o,
    output logic              timeout_o
);

    psr_state_e state_q, state_d;
    logic       sfu_q, err_q, tmo_q, wreq_q;
    logic       idle_reached, ack_expired;
    logic       tmo_set, illegal_req;
    logic       sfu_done;
    wake_code_e wake_code;

    psr_idle_tracker #(
        .IDLE_W   (IDLE_W),
        .MIN_IDLE (MIN_IDLE)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == PSR_ENTRY),
        .vsync_i   (vsync_i),
        .upd_i     (upd_i),
        .cfg_i     (idle_cfg_i),
        .reached_o (idle_reached)
    );

    psr_wake_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == PSR_EXIT),
        .limit_i  (ack_limit_i),
        .expire_o (ack_expired)
    );

    psr_wake_encode #(
        .VAL_W (WAKE_W)
    ) u_enc (
        .req_i  (wake_time_i),
        .code_o (wake_code)
    );

    // Next-state selection; disable outranks exit, exit outranks frame update.
    always_comb begin
        state_d = state_q;
        tmo_set = 1'b0;
        case (state_q)
            PSR_OFF:    if (enable_i) state_d = PSR_IDLE;
            PSR_IDLE: begin
                if (!enable_i)       state_d = PSR_OFF;
                else if (activate_i) state_d = PSR_ENTRY;
            end
            PSR_ENTRY:  if (idle_reached) state_d = PSR_ACTIVE;
            PSR_ACTIVE: begin
                if (!enable_i)               state_d = PSR_OFF;
                else if (exit_i)             state_d = PSR_EXIT;
                else if (sfu_q && vsync_i)   state_d = PSR_SFU;
            end
            PSR_SFU: begin
                if (!enable_i)    state_d = PSR_OFF;
                else if (exit_i)  state_d = PSR_EXIT;
                else if (vsync_i) state_d = PSR_ACTIVE;
            end
            PSR_EXIT: begin
                if (wake_ack_i) begin
                    state_d = PSR_IDLE;
                end else if (ack_expired) begin
                    state_d = PSR_IDLE;
                    tmo_set = 1'b1;
                end
            end
            default:    state_d = PSR_OFF;
        endcase
    end

    // Classify requests that the current state does not accept.
    always_comb illegal_req =
        (activate_i && state_q != PSR_IDLE) ||
        (exit_i && state_q != PSR_ACTIVE && state_q != PSR_SFU) ||
        (sfu_req_i && state_q == PSR_OFF);

    // The one-frame update completes on the return from state 4 to state 3.
    always_comb sfu_done = (state_q == PSR_SFU) && (state_d == PSR_ACTIVE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PSR_OFF;
        else        state_q <= state_d;
    end

    // Wake strobe marks the first cycle spent in exit.
    always_ff @(posedge clk) begin
        if (!rst_n) wreq_q <= 1'b0;
        else        wreq_q <= (state_d == PSR_EXIT) && (state_q != PSR_EXIT);
    end

    // Single-frame pending flag: a new request wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sfu_q <= 1'b0;
        else if (sfu_req_i && state_q != PSR_OFF)
            sfu_q <= 1'b1;
        else if (sfu_done || state_d == PSR_OFF)
            sfu_q <= 1'b0;
    end

    // Sticky error and timeout flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            if (illegal_req) err_q <= 1'b1;
            if (tmo_set)     tmo_q <= 1'b1;
        end
    end

    // Output mapping.
    always_comb begin
        state_o     = state_q;
        in_trans_o  = (state_q == PSR_ENTRY) || (state_q == PSR_EXIT);
        wake_req_o  = wreq_q;
        wake_code_o = wake_code;
        sfu_pend_o  = sfu_q;
        err_o       = err_q;
        timeout_o   = tmo_q;
    end

endmodule

// File: rtl/psr_src_ctrl_chk.sv
// Temporal checks for the self-refresh sequencer, attached by bind.
// Assumes: it sees only top-level ports.
module psr_src_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       activate_i,
    input logic       exit_i,
    input logic [2:0] state_o,
    input logic       wake_req_o,
    input logic       sfu_pend_o,
    input logic       err_o,
    input logic       timeout_o
);

    // R1
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5);

    // R2
    enable_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && enable_i) |=> state_o == 3'd1);

    // R3
    activate_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && enable_i && activate_i) |=> state_o == 3'd2);

    // R5
    exit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && enable_i && exit_i) |=> state_o == 3'd5);

    // R6
    wake_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (state_o == 3'd5 && $past(state_o) != 3'd5));

    // R7
    sfu_flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> sfu_pend_o);

    // R10
    entry_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |=> state_o != 3'd0);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R12
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> timeout_o);

endmodule

bind psr_src_ctrl psr_src_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .activate_i (activate_i),
    .exit_i     (exit_i),
    .state_o    (state_o),
    .wake_req_o (wake_req_o),
    .sfu_pend_o (sfu_pend_o),
    .err_o      (err_o),
    .timeout_o  (timeout_o)
);

// File: tb/psr_src_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle plus directed checks.
module psr_src_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 0, activate_i = 0, exit_i = 0, sfu_req_i = 0;
    logic        vsync_i = 0, upd_i = 0, wake_ack_i = 0;
    logic [3:0]  idle_cfg_i = 4'd2;
    logic [3:0]  wake_time_i = 4'd0;
    logic [15:0] ack_limit_i = 16'd10;
    logic [2:0]  state_o;
    logic        in_trans_o, wake_req_o, sfu_pend_o, err_o, timeout_o;
    logic [1:0]  wake_code_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model state
    int m_state = 0, m_cnt = 0, m_tcnt = 0;
    bit m_dirty = 0, m_sfu = 0, m_err = 0, m_tmo = 0, m_wreq = 0;

    always #2.5 clk = ~clk;

    psr_src_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .activate_i(activate_i),
        .exit_i(exit_i), .sfu_req_i(sfu_req_i), .vsync_i(vsync_i), .upd_i(upd_i),
        .idle_cfg_i(idle_cfg_i), .wake_time_i(wake_time_i), .ack_limit_i(ack_limit_i),
        .wake_ack_i(wake_ack_i), .state_o(state_o), .in_trans_o(in_trans_o),
        .wake_req_o(wake_req_o), .wake_code_o(wake_code_o), .sfu_pend_o(sfu_pend_o),
        .err_o(err_o), .timeout_o(timeout_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int nxt, thr;
        bit dirty_now;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_tcnt = 0; m_dirty = 0;
            m_sfu = 0; m_err = 0; m_tmo = 0; m_wreq = 0;
        end else begin
            thr = (idle_cfg_i < 6) ? 6 : int'(idle_cfg_i);
            nxt = m_state;
            if ((activate_i && m_state != 1) ||
                (exit_i && m_state != 3 && m_state != 4) ||
                (sfu_req_i && m_state == 0)) m_err = 1;
            case (m_state)
                0: if (enable_i) nxt = 1;
                1: if (!enable_i) nxt = 0; else if (activate_i) nxt = 2;
                2: if (vsync_i) begin
                       dirty_now = m_dirty || upd_i;
                       if (!dirty_now && m_cnt + 1 >= thr) nxt = 3;
                   end
                3: if (!enable_i) nxt = 0; else if (exit_i) nxt = 5;
                   else if (m_sfu && vsync_i) nxt = 4;
                4: if (!enable_i) nxt = 0; else if (exit_i) nxt = 5;
                   else if (vsync_i) nxt = 3;
                5: if (wake_ack_i) nxt = 1;
                   else if (m_tcnt == int'(ack_limit_i)) begin nxt = 1; m_tmo = 1; end
                default: nxt = 0;
            endcase
            if (m_state == 2) begin
                if (vsync_i) begin
                    m_cnt = (m_dirty || upd_i) ? 0 : m_cnt + 1;
                    m_dirty = 0;
                end else if (upd_i) m_dirty = 1;
            end else begin
                m_cnt = 0; m_dirty = 0;
            end
            m_tcnt = (m_state == 5) ? m_tcnt + 1 : 0;
            if (sfu_req_i && m_state != 0) m_sfu = 1;
            else if ((m_state == 4 && nxt == 3) || nxt == 0) m_sfu = 0;
            m_wreq = (nxt == 5 && m_state != 5);
            m_state = nxt;
        end
    end

    // Compare the design against the model mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 state", state_o, m_state);
            chk("R9 in_trans", in_trans_o, (m_state == 2 || m_state == 5));
            chk("R6 wake_req", wake_req_o, m_wreq);
            chk("R7 sfu_pend", sfu_pend_o, m_sfu);
            chk("R11 err", err_o, m_err);
            chk("R12 timeout", timeout_o, m_tmo);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic vs(input bit u);
        vsync_i = 1; upd_i = u; cyc();
        vsync_i = 0; upd_i = 0; cyc(); cyc(); cyc();
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog act=%0d exp=0", cycles);
            finish_run();
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1; #0.5;
        // R1 reset state
        chk("R1 reset state", state_o, 0);
        chk("R1 reset flags", {wake_req_o, sfu_pend_o, err_o, timeout_o}, 0);

        // R8 wake code mapping
        wake_time_i = 0;  #1 chk("R8 v0", wake_code_o, 0);
        wake_time_i = 1;  #1 chk("R8 v1", wake_code_o, 1);
        wake_time_i = 2;  #1 chk("R8 v2", wake_code_o, 2);
        wake_time_i = 5;  #1 chk("R8 v5", wake_code_o, 2);
        wake_time_i = 6;  #1 chk("R8 v6", wake_code_o, 3);
        wake_time_i = 15; #1 chk("R8 v15", wake_code_o, 3);
        cyc();

        // R2 enable only reaches idle
        enable_i = 1; cyc();
        chk("R2 enable", state_o, 1);
        for (int i = 0; i < 5; i++) cyc();
        chk("R2 stays idle", state_o, 1);

        // R3 activate, R9 in transition
        activate_i = 1; cyc(); activate_i = 0;
        chk("R3 entry", state_o, 2);
        chk("R9 entry flag", in_trans_o, 1);

        // R4 clamp to 6, dirty frame restarts count
        vs(0); vs(0); vs(1);
        for (int i = 0; i < 5; i++) vs(0);
        chk("R4 five clean frames", state_o, 2);
        vs(0);
        chk("R4 sixth clean frame", state_o, 3);
        chk("R9 active flag", in_trans_o, 0);

        // R5/R6 exit with acknowledge
        exit_i = 1; cyc(); exit_i = 0;
        chk("R5 exit direct", state_o, 5);
        chk("R6 wake strobe", wake_req_o, 1);
        cyc();
        chk("R6 strobe one cycle", wake_req_o, 0);
        wake_ack_i = 1; cyc(); wake_ack_i = 0;
        chk("R6 ack returns idle", state_o, 1);

        // R7 single-frame update
        sfu_req_i = 1; cyc(); sfu_req_i = 0;
        chk("R7 pending set", sfu_pend_o, 1);
        activate_i = 1; cyc(); activate_i = 0;
        for (int i = 0; i < 6; i++) vs(0);
        chk("R7 active with pending", state_o, 3);
        vs(0);
        chk("R7 update frame", state_o, 4);
        vs(0);
        chk("R7 back active", state_o, 3);
        chk("R7 pending cleared", sfu_pend_o, 0);

        // R12 acknowledge timeout
        exit_i = 1; cyc(); exit_i = 0;
        for (int i = 0; i < 10; i++) cyc();
        chk("R12 still waiting", state_o, 5);
        chk("R12 no timeout yet", timeout_o, 0);
        cyc();
        chk("R12 timeout idle", state_o, 1);
        chk("R12 timeout flag", timeout_o, 1);

        // R11 illegal exit ignored
        chk("R11 err clear", err_o, 0);
        exit_i = 1; cyc(); exit_i = 0;
        chk("R11 exit ignored", state_o, 1);
        chk("R11 err set", err_o, 1);

        // R10 disable during entry waits; R4 threshold above clamp
        idle_cfg_i = 4'd9;
        activate_i = 1; cyc(); activate_i = 0;
        enable_i = 0;
        for (int i = 0; i < 8; i++) vs(0);
        chk("R10 entry held", state_o, 2);
        chk("R4 eight of nine", state_o, 2);
        vsync_i = 1; cyc(); vsync_i = 0;
        chk("R4 ninth frame", state_o, 3);
        cyc();
        chk("R10 then off", state_o, 0);
        enable_i = 1; cyc();
        enable_i = 0; cyc();
        chk("R10 idle to off", state_o, 0);

        cyc(); cyc();
        finish_run();
    end

endmodule